// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an asynchronous static RAM of 524,288 bytes whose data pins are shared for reading and writing. The host asks for one access at a time by raising a request with a write flag, a 19-bit address and, for writes, a byte of data. The controller then plays out the pin sequence the memory needs: chip select, write enable and output enable (all active low), a registered address, a data-out bus with its drive enable, and a data-in bus that is sampled at the end of a read.

Every interval is counted in clock cycles. Each count comes from a speed-grade parameter and the clock period: the nanosecond figure is divided by the period, rounded up, and never taken below one. Writes are strobed on write enable while output enable is held high, so the shorter write pulse limit applies. Before the controller drives the shared bus, it waits out a gap long enough for the memory's outputs to float. When an access finishes, the block gives a one-cycle done strobe. The read byte stays on its output until the next read completes.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and straight after it, chip select, write enable and output enable are high, the data-drive enable is low and done is low.
- R2: A read accepted at a clock edge holds chip select and output enable low, with write enable high, for N_RD+1 cycles, where N_RD covers the longer of the address access time and the output-enable access time. At the edge that ends those cycles it captures the data-in bus into the read data output.
- R3: A write accepted at a clock edge first spends N_TA cycles with all strobes high and the bus released. It then has N_SU cycles with chip select low and data driven, N_WP cycles with write enable also low, and N_WR cycles with write enable high again, chip select still low and data still driven.
- R4: Write enable and output enable are never low in the same cycle, and output enable stays high for the whole write.
- R5: The data-drive enable rises only after a cycle in which output enable was already high. It is never high while output enable is low.
- R6: The memory address and the data-out bus keep the values captured at acceptance for as long as chip select stays low, even when the host inputs change.
- R7: Done is high for exactly one cycle, the first idle cycle after an access. Read data changes only in a cycle where done is high.
- R8: A request raised while an access is in progress is ignored. It causes no extra memory cycle and no write.
- R9: Each count is ceil(ns / CLK_PERIOD_NS), with a minimum of one. SPEED_GRADE 0, 1 and 2 select the 17, 20 and 25 ns timing sets. The data setup, pulse width, chip-select-to-end and address-to-end limits all fold into N_WP.
- R10: A byte that is written reads back at the same address, including address 0 and the top address 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Access request, taken only while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Host byte address |
| wdata_i | input | 8 | Host write byte |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 8 | Last read byte, held |
| mem_addr_o | output | 19 | Memory address pins |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dout_o | output | 8 | Byte to drive onto the shared bus |
| mem_drive_o | output | 1 | High when the controller drives the shared bus |
| mem_din_i | input | 8 | Byte read from the shared bus |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of an access. That request must leave no trace, and the captured address and data must survive host inputs that change under them. The stimulus raises a write request with a different address partway through a read, and a read request partway through a write. It also scrambles the host address and data right after acceptance. Later reads of the poked address then show that no write took place. The memory model places valid read data on the bus only once N_RD full cycles have passed, so a capture one cycle early returns a poison byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_CAP,
    ST_TURN,
    ST_WR_SU,
    ST_WR_PULSE,
    ST_WR_REC
  } ctrl_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Read: longer of address access and output-enable access.
  function automatic int read_ns(input int grade);
    case (grade)
      0:       return max2(17, 8);
      1:       return max2(20, 10);
      default: return max2(25, 12);
    endcase
  endfunction

  // Output float time after output enable rises.
  function automatic int turn_ns(input int grade);
    case (grade)
      0:       return 7;
      1:       return 8;
      default: return 10;
    endcase
  endfunction

  // Write strobe: pulse width (OE high), CS to end, address to end, data setup.
  function automatic int wpulse_ns(input int grade);
    case (grade)
      0:       return max2(max2(12, 12), max2(12, 8));
      1:       return max2(max2(13, 13), max2(13, 9));
      default: return max2(max2(15, 15), max2(15, 10));
    endcase
  endfunction

  function automatic int addr_setup_ns(input int grade);
    return (grade < 0) ? 1 : 0;
  endfunction

  function automatic int recover_ns(input int grade);
    return (grade < 0) ? 1 : 0;
  endfunction

  function automatic int ns_to_cycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int N_RD = 3,
  parameter int N_TA = 1,
  parameter int N_SU = 1,
  parameter int N_WP = 2,
  parameter int N_WR = 1,
  parameter int CW   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  output logic        accept,
  output logic        capture,
  output logic        done,
  output ctrl_state_e state
);

  ctrl_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    done_d  = 1'b0;
    accept  = 1'b0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          if (wr) begin
            state_d = ST_TURN;
            cnt_d   = CW'(N_TA - 1);
          end else begin
            state_d = ST_RD_ACC;
            cnt_d   = CW'(N_RD - 1);
          end
        end
      end
      ST_RD_ACC: if (cnt_zero) state_d = ST_RD_CAP;
      ST_RD_CAP: begin
        state_d = ST_IDLE;
        capture = 1'b1;
        done_d  = 1'b1;
      end
      ST_TURN: if (cnt_zero) begin
        state_d = ST_WR_SU;
        cnt_d   = CW'(N_SU - 1);
      end
      ST_WR_SU: if (cnt_zero) begin
        state_d = ST_WR_PULSE;
        cnt_d   = CW'(N_WP - 1);
      end
      ST_WR_PULSE: if (cnt_zero) begin
        state_d = ST_WR_REC;
        cnt_d   = CW'(N_WR - 1);
      end
      ST_WR_REC: if (cnt_zero) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign done  = done_q;

  // R8: a new access starts only from idle
  p_accept_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_RD_ACC) || ($past(state_q) == ST_RD_ACC));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  ctrl_state_e state,
  output logic        cs_n,
  output logic        we_n,
  output logic        oe_n,
  output logic        drive
);

  always_comb begin
    cs_n  = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    drive = 1'b0;
    case (state)
      ST_RD_ACC, ST_RD_CAP: begin
        cs_n = 1'b0;
        oe_n = 1'b0;
      end
      ST_WR_SU, ST_WR_REC: begin
        cs_n  = 1'b0;
        drive = 1'b1;
      end
      ST_WR_PULSE: begin
        cs_n  = 1'b0;
        we_n  = 1'b0;
        drive = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic          load_rd,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] wdata_out,
  output logic [DW-1:0] rdata_out
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_req) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (load_rd) rdata_q <= bus_in;
  end

  assign addr_out  = addr_q;
  assign wdata_out = wdata_q;
  assign rdata_out = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 2,
  parameter int AW            = 19,
  parameter int DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_cs_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [DW-1:0] mem_dout_o,
  output logic          mem_drive_o,
  input  logic [DW-1:0] mem_din_i
);

  // R9: interval counts
  localparam int N_RD  = ns_to_cycles(read_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int N_TA  = ns_to_cycles(turn_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int N_SU  = ns_to_cycles(addr_setup_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int N_WP  = ns_to_cycles(wpulse_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int N_WR  = ns_to_cycles(recover_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int N_MAX = max2(max2(max2(N_RD, N_TA), max2(N_SU, N_WP)), N_WR);
  localparam int CW    = $clog2(N_MAX + 1);

  ctrl_state_e state;
  logic        accept, capture;

  sram_ctrl_seq #(
    .N_RD(N_RD), .N_TA(N_TA), .N_SU(N_SU), .N_WP(N_WP), .N_WR(N_WR), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req_i), .wr(wr_i),
    .accept(accept), .capture(capture), .done(done_o), .state(state)
  );

  sram_pin_decode u_pins (
    .state(state), .cs_n(mem_cs_n_o), .we_n(mem_we_n_o),
    .oe_n(mem_oe_n_o), .drive(mem_drive_o)
  );

  sram_data_path #(.AW(AW), .DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .load_req(accept), .load_rd(capture),
    .addr_in(addr_i), .wdata_in(wdata_i), .bus_in(mem_din_i),
    .addr_out(mem_addr_o), .wdata_out(mem_dout_o), .rdata_out(rdata_o)
  );

  // R4: strobes never overlap
  p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n_o && !mem_oe_n_o));

  // R3: write enable only inside a selected cycle
  p_we_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> !mem_cs_n_o);

  // R5: bus drive never overlaps output enable and starts after a gap
  p_drive_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drive_o |-> mem_oe_n_o);
  p_drive_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_drive_o) |-> $past(mem_oe_n_o) && $past(mem_cs_n_o));

  // R6: address and write data held while selected
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o) && $stable(mem_dout_o));

  // R7: read data changes only together with done
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rdata_o));

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  // 25 ns grade figures
  localparam int B_RD = cyc(25);
  localparam int B_TA = cyc(10);
  localparam int B_SU = cyc(0);
  localparam int B_WP = cyc(15);
  localparam int B_WR = cyc(0);

  typedef struct packed {
    logic cs, we, oe, drv, dn;
  } ph_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        done;
  logic [7:0]  rdata;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_drive;
  logic [7:0]  mem_dout, mem_din;

  int total = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(CLK_PERIOD), .SPEED_GRADE(2)) u_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .done_o(done), .rdata_o(rdata), .mem_addr_o(mem_addr), .mem_cs_n_o(mem_cs_n),
    .mem_we_n_o(mem_we_n), .mem_oe_n_o(mem_oe_n), .mem_dout_o(mem_dout),
    .mem_drive_o(mem_drive), .mem_din_i(mem_din)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fill(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h3C;
  endfunction

  // behavioural memory model
  logic [7:0] model_mem [int];
  logic [7:0] sb [int];
  int rd_cnt = 0, we_cnt = 0;
  logic [18:0] w_addr;
  logic [7:0]  w_dat;

  function automatic logic [7:0] model_rd(input logic [18:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : fill(a);
  endfunction

  function automatic logic [7:0] sb_rd(input logic [18:0] a);
    return sb.exists(int'(a)) ? sb[int'(a)] : fill(a);
  endfunction

  assign mem_din = (!mem_cs_n && !mem_oe_n && rd_cnt >= B_RD + 1) ? model_rd(mem_addr) : 8'hEE;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n && !mem_oe_n) chk("R4 strobe overlap", 1, 0);
      if (mem_drive && !mem_oe_n) chk("R5 drive during OE", 1, 0);
      if (!mem_cs_n && !mem_oe_n) rd_cnt = rd_cnt + 1;
      else rd_cnt = 0;
      if (!mem_we_n) begin
        if (mem_cs_n) chk("R3 WE without CS", 1, 0);
        we_cnt = we_cnt + 1;
        w_addr = mem_addr;
        w_dat  = mem_dout;
      end else if (we_cnt > 0) begin
        chk("R9 write pulse cycles", we_cnt, B_WP);
        model_mem[int'(w_addr)] = w_dat;
        we_cnt = 0;
      end
    end
  end

  task automatic run_op(input bit is_wr, input logic [18:0] a, input logic [7:0] d,
                        input bit poke, input logic [18:0] pa, input logic [7:0] pd);
    ph_t q[$];
    ph_t e;
    logic [7:0] rd_before;
    string tg;
    tg = is_wr ? "R3" : "R2";
    if (!is_wr) begin
      repeat (B_RD + 1) q.push_back('{1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
    end else begin
      repeat (B_TA) q.push_back('{1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
      repeat (B_SU) q.push_back('{1'b0, 1'b1, 1'b1, 1'b1, 1'b0});
      repeat (B_WP) q.push_back('{1'b0, 1'b0, 1'b1, 1'b1, 1'b0});
      repeat (B_WR) q.push_back('{1'b0, 1'b1, 1'b1, 1'b1, 1'b0});
      sb[int'(a)] = d;
    end
    q.push_back('{1'b1, 1'b1, 1'b1, 1'b0, 1'b1});
    rd_before = rdata;
    @(negedge clk);
    req = 1'b1; wr = is_wr; addr = a; wdata = d;
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      if (i == 0) begin req = 1'b0; addr = ~a; wdata = ~d; end
      if (poke && i == 1) begin req = 1'b1; wr = ~is_wr; addr = pa; wdata = pd; end
      if (poke && i == 2) req = 1'b0;
      e = q[i];
      chk({tg, " R9 cs_n"}, mem_cs_n, e.cs);
      chk({tg, " R4 we_n/oe_n"}, {mem_we_n, mem_oe_n}, {e.we, e.oe});
      chk({tg, " R5 drive"}, mem_drive, e.drv);
      chk({tg, " R7 done"}, done, e.dn);
      if (!e.cs) chk({tg, " R6 address held"}, mem_addr, a);
      if (e.drv) chk({tg, " R6 data held"}, mem_dout, d);
      if (!e.dn && !is_wr) chk("R7 rdata held before done", rdata, rd_before);
    end
    if (!is_wr) chk("R10 read data", rdata, sb_rd(a));
    rd_before = rdata;
    @(negedge clk);
    chk("R7 done low after pulse", done, 0);
    chk("R7 rdata held after done", rdata, rd_before);
    chk("R8 no stray cycle", mem_cs_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", mem_cs_n, 1);
    chk("R1 we_n/oe_n in reset", {mem_we_n, mem_oe_n}, 2'b11);
    chk("R1 drive in reset", mem_drive, 0);
    chk("R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_drive, done}, 5'b11100);

    run_op(0, 19'h00000, 8'h00, 0, '0, '0);
    run_op(1, 19'h12345, 8'hA5, 0, '0, '0);
    run_op(0, 19'h12345, 8'h00, 0, '0, '0);
    run_op(1, 19'h7FFFF, 8'h3C, 0, '0, '0);
    run_op(0, 19'h7FFFF, 8'h00, 0, '0, '0);
    run_op(1, 19'h00000, 8'hFF, 0, '0, '0);
    run_op(0, 19'h00000, 8'h00, 0, '0, '0);
    // R8: write request raised mid-read must not land
    run_op(0, 19'h12345, 8'h00, 1, 19'h00001, 8'h99);
    run_op(0, 19'h00001, 8'h00, 0, '0, '0);
    // R8: read request raised mid-write must not start
    run_op(1, 19'h2AAAA, 8'h5A, 1, 19'h55555, 8'h00);
    run_op(0, 19'h2AAAA, 8'h00, 0, '0, '0);
    run_op(0, 19'h55555, 8'h00, 0, '0, '0);
    for (int k = 0; k < 8; k++) begin
      run_op(1, 19'(k * 19'h0F0F1), 8'(k * 37 + 1), 0, '0, '0);
    end
    for (int k = 7; k >= 0; k--) begin
      run_op(0, 19'(k * 19'h0F0F1), 8'h00, 0, '0, '0);
    end
    chk("R10 model agrees at top address", model_rd(19'h7FFFF), 8'h3C);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule